// File: doc/BRIEF.md
# DDR3 Initialisation and Read-Gate Training Sequencer

This block runs DDR3 memory bring-up in hardware once the memory controller reports that its power-up phase is finished. It sends the JEDEC start-up commands to the controller's command port one at a time. For each command it waits until the port reports that it is idle again before it sends the next one. The four mode-register values come in as inputs. The sequencer targets both ranks with every command and inserts a programmable idle gap after the initial deselect.

After the start-up commands the block runs read-gate (DQS squelch) calibration on a two-lane, 16-bit PHY. First it saves the controller's refresh-interval value and writes zero to it, which stops auto-refresh. Then it raises one calibration-start strobe for all lanes and waits for every lane to report done. After that it sends a short burst of refresh commands to make up for the refreshes missed during training, and writes the saved interval back. A timeout on calibration stops everything and raises an error flag. The calibration engine itself is outside this block and is seen only through its per-lane done bits.

Top module: `ddr3_bringup_seq`

## Requirements
- R1: After reset, `cmd_req`, `refi_wr_en`, `cal_start`, `seq_done` and `seq_err` are all low. No command and no refresh-interval write happens while `pwr_up_done` is low.
- R2: Every command carries `cmd_rank` with all bits set, so both ranks are addressed together.
- R3: The command codes are deselect=0, precharge-all=1, refresh=2, mode-register set=3 and ZQ long calibration=5. The init order is deselect, precharge-all, MRS to bank 2, MRS to bank 3, MRS to bank 1, MRS to bank 0, then ZQ long. Non-MRS commands carry bank 0 and address 0.
- R4: Each MRS carries the matching `mode_regN` input on `cmd_addr`. The bank-0 write also forces bit 8 (DLL reset) to 1 and leaves all other bits as given.
- R5: `cmd_busy` is ignored in the cycle right after a request. Once `cmd_busy` is seen low, the next request follows two cycles later. Precharge-all comes `DESEL_GAP` cycles later than that.
- R6: After ZQ long completes, `refi_wr_en` pulses for one cycle with data 0. The `refi_rd` value present in that cycle is kept as the saved interval.
- R7: `cal_start` rises only after the zero write. It stays high until `cal_done` has bit 0 (low byte lane) and bit 1 (high byte lane) both set, then falls. One lane alone does not end it.
- R8: After calibration, exactly three refresh commands are issued. Then `refi_wr_en` pulses once with the saved interval, whatever `refi_rd` reads by then. After that `seq_done` goes high and stays high, and nothing more is issued.
- R9: If both lanes are not done within `CAL_TIMEOUT` cycles, `cal_start` stays high for exactly `CAL_TIMEOUT` cycles and then falls. `seq_err` then goes high and stays high, and no further command or write follows.
- R10: `cmd_req` is a single-cycle pulse. It is only raised when `cmd_busy` was low in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_up_done | input | 1 | Controller power-up phase finished |
| mode_reg0 | input | MR_W | Mode register 0 value |
| mode_reg1 | input | MR_W | Mode register 1 value |
| mode_reg2 | input | MR_W | Mode register 2 value |
| mode_reg3 | input | MR_W | Mode register 3 value |
| cmd_busy | input | 1 | Command port still executing |
| cmd_req | output | 1 | Command request pulse |
| cmd_code | output | 4 | Command code |
| cmd_rank | output | RANKS | Rank select mask |
| cmd_bank | output | BANK_W | Bank address |
| cmd_addr | output | MR_W | Command address / mode value |
| refi_rd | input | REFI_W | Current refresh-interval value |
| refi_wr_en | output | 1 | Refresh-interval write strobe |
| refi_wr_data | output | REFI_W | Refresh-interval write value |
| cal_start | output | 1 | Gate calibration start, all lanes |
| cal_done | input | LANES | Per-lane calibration done |
| seq_done | output | 1 | Sequence complete |
| seq_err | output | 1 | Calibration timed out |

## Verification
The bench builds the block with `DESEL_GAP`=3 and `CAL_TIMEOUT`=12 and keeps the other parameters at their defaults. With these small values the post-deselect gap can be measured to the exact cycle, and the timeout is reached in a few cycles. This lets the bench sweep command-port busy lengths from 0 to 3 against lane-done latencies on both sides of the timeout. The sweep includes the case where completion arrives exactly at the last allowed cycle. Mode values are computed per run, with bit 8 of the bank-0 value both set and clear. The refresh-interval input is changed during training to show that the saved value, not the live one, is restored.

// File: rtl/ddr3_seq_pkg.sv
// Shared definitions for the DDR3 bring-up sequencer.
// Assumes a controller command port that decodes the 4-bit codes below.
package ddr3_seq_pkg;

    localparam logic [3:0] CMD_DESELECT = 4'd0;
    localparam logic [3:0] CMD_PRECH_ALL = 4'd1;
    localparam logic [3:0] CMD_REFRESH  = 4'd2;
    localparam logic [3:0] CMD_MODE_SET = 4'd3;
    localparam logic [3:0] CMD_ZQ_LONG  = 4'd5;

    typedef enum logic [3:0] {
        ST_WAIT_PWR,
        ST_DESEL,
        ST_GAP,
        ST_PRECH,
        ST_MRS2,
        ST_MRS3,
        ST_MRS1,
        ST_MRS0,
        ST_ZQ,
        ST_SAVE_REFI,
        ST_TRAIN,
        ST_REF_BURST,
        ST_RESTORE_REFI,
        ST_FINISHED,
        ST_FAILED
    } seq_state_e;

    typedef enum logic [1:0] {
        IS_IDLE,
        IS_SETTLE,
        IS_WAIT
    } issue_state_e;

    typedef enum logic [1:0] {
        GC_IDLE,
        GC_RUN,
        GC_PASS,
        GC_TIMEOUT
    } gate_state_e;

endpackage

// File: rtl/seq_cmd_issuer.sv
// Command issuer: sends one command to the controller port and reports
// completion. It latches the fields on issue, pulses cmd_req for one cycle,
// ignores busy for one cycle (the port registers the request), and then
// waits for busy to clear.
// Assumes: cmd_busy, if it rises at all, rises in the cycle after cmd_req.
module seq_cmd_issuer
    import ddr3_seq_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [3:0]        code_in,
    input  logic [BANK_W-1:0] bank_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              cmd_busy,
    output logic              cmd_req,
    output logic [3:0]        cmd_code,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              ack
);

    issue_state_e st;

    // Completion is reported once busy is seen low after the settle cycle.
    always_comb ack = (st == IS_WAIT) && !cmd_busy;

    // Issue handshake: idle -> request pulse -> settle -> wait for idle port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= IS_IDLE;
            cmd_req  <= 1'b0;
            cmd_code <= '0;
            cmd_bank <= '0;
            cmd_addr <= '0;
        end else begin
            cmd_req <= 1'b0;
            case (st)
                IS_IDLE: begin
                    if (go && !cmd_busy) begin
                        cmd_req  <= 1'b1;
                        cmd_code <= code_in;
                        cmd_bank <= bank_in;
                        cmd_addr <= addr_in;
                        st       <= IS_SETTLE;
                    end
                end
                IS_SETTLE: st <= IS_WAIT;
                IS_WAIT: begin
                    if (!cmd_busy) st <= IS_IDLE;
                end
                default: st <= IS_IDLE;
            endcase
        end
    end

    // R10: request lasts exactly one cycle
    p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req |=> !cmd_req);

    // R10: a request is only launched from an idle port
    p_req_port_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req |-> $past(!cmd_busy));

endmodule

// File: rtl/seq_gate_cal.sv
// Read-gate calibration control: raises one start strobe for all lanes,
// waits for every lane's done bit, then drops the strobe. A cycle counter
// bounds the wait; on expiry the strobe drops and a timeout is reported.
// Assumes: done bits are levels that stay up while start is high.
module seq_gate_cal
    import ddr3_seq_pkg::*;
#(
    parameter int LANES   = 2,
    parameter int TIMEOUT = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [LANES-1:0] cal_done,
    output logic             cal_start,
    output logic             finished,
    output logic             timed_out
);

    localparam int CNT_W = $clog2(TIMEOUT + 1);

    gate_state_e      st;
    logic [CNT_W-1:0] cnt;
    logic             all_done;

    // All lanes must report done together.
    always_comb all_done = &cal_done;

    // Result flags held until the caller releases go.
    always_comb begin
        finished  = (st == GC_PASS);
        timed_out = (st == GC_TIMEOUT);
    end

    // Strobe and timeout counter control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= GC_IDLE;
            cnt       <= '0;
            cal_start <= 1'b0;
        end else begin
            case (st)
                GC_IDLE: begin
                    if (go) begin
                        cal_start <= 1'b1;
                        cnt       <= '0;
                        st        <= GC_RUN;
                    end
                end
                GC_RUN: begin
                    if (all_done) begin
                        cal_start <= 1'b0;
                        st        <= GC_PASS;
                    end else if (cnt == CNT_W'(TIMEOUT - 1)) begin
                        cal_start <= 1'b0;
                        st        <= GC_TIMEOUT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                GC_PASS, GC_TIMEOUT: begin
                    if (!go) st <= GC_IDLE;
                end
                default: st <= GC_IDLE;
            endcase
        end
    end

    // R7: strobe drops once every lane is done
    p_start_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_start && all_done) |=> !cal_start);

    // R9: the wait counter never passes its limit
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(TIMEOUT - 1));

endmodule

// File: rtl/ddr3_bringup_seq.sv
// DDR3 bring-up sequencer top. Waits for controller power-up, issues the
// start-up command list to both ranks, pauses refresh, runs read-gate
// calibration, makes up missed refreshes and restores the refresh interval.
// Assumes: DESEL_GAP >= 1, CAL_TIMEOUT >= 1, DLL_RST_BIT < MR_W.
module ddr3_bringup_seq
    import ddr3_seq_pkg::*;
#(
    parameter int MR_W        = 13,
    parameter int BANK_W      = 3,
    parameter int RANKS       = 2,
    parameter int LANES       = 2,
    parameter int REFI_W      = 16,
    parameter int DESEL_GAP   = 8,
    parameter int CAL_TIMEOUT = 4096,
    parameter int REF_BURST   = 3,
    parameter int DLL_RST_BIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_up_done,
    input  logic [MR_W-1:0]   mode_reg0,
    input  logic [MR_W-1:0]   mode_reg1,
    input  logic [MR_W-1:0]   mode_reg2,
    input  logic [MR_W-1:0]   mode_reg3,
    input  logic              cmd_busy,
    output logic              cmd_req,
    output logic [3:0]        cmd_code,
    output logic [RANKS-1:0]  cmd_rank,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [MR_W-1:0]   cmd_addr,
    input  logic [REFI_W-1:0] refi_rd,
    output logic              refi_wr_en,
    output logic [REFI_W-1:0] refi_wr_data,
    output logic              cal_start,
    input  logic [LANES-1:0]  cal_done,
    output logic              seq_done,
    output logic              seq_err
);

    localparam int GAP_W = $clog2(DESEL_GAP + 1);
    localparam int REF_W = $clog2(REF_BURST + 1);
    localparam logic [MR_W-1:0] DLL_RST_MASK = MR_W'(1) << DLL_RST_BIT;

    seq_state_e        state;
    logic [GAP_W-1:0]  gap_cnt;
    logic [REF_W-1:0]  ref_cnt;
    logic [REFI_W-1:0] saved_refi;

    logic              issue_go;
    logic [3:0]        issue_code;
    logic [BANK_W-1:0] issue_bank;
    logic [MR_W-1:0]   issue_addr;
    logic              issue_ack;

    logic              gate_go;
    logic              gate_pass;
    logic              gate_tmo;

    // Every command addresses all ranks at once.
    always_comb cmd_rank = '1;

    // Command selection for the current step.
    always_comb begin
        issue_go   = 1'b1;
        issue_code = CMD_DESELECT;
        issue_bank = '0;
        issue_addr = '0;
        case (state)
            ST_DESEL:     issue_code = CMD_DESELECT;
            ST_PRECH:     issue_code = CMD_PRECH_ALL;
            ST_MRS2: begin
                issue_code = CMD_MODE_SET;
                issue_bank = BANK_W'(2);
                issue_addr = mode_reg2;
            end
            ST_MRS3: begin
                issue_code = CMD_MODE_SET;
                issue_bank = BANK_W'(3);
                issue_addr = mode_reg3;
            end
            ST_MRS1: begin
                issue_code = CMD_MODE_SET;
                issue_bank = BANK_W'(1);
                issue_addr = mode_reg1;
            end
            ST_MRS0: begin
                issue_code = CMD_MODE_SET;
                issue_bank = '0;
                issue_addr = mode_reg0 | DLL_RST_MASK;
            end
            ST_ZQ:        issue_code = CMD_ZQ_LONG;
            ST_REF_BURST: issue_code = CMD_REFRESH;
            default:      issue_go   = 1'b0;
        endcase
    end

    // Refresh-interval writes: zero before training, saved value after.
    always_comb begin
        refi_wr_en   = (state == ST_SAVE_REFI) || (state == ST_RESTORE_REFI);
        refi_wr_data = (state == ST_RESTORE_REFI) ? saved_refi : '0;
    end

    // Calibration runs only in the training step.
    always_comb gate_go = (state == ST_TRAIN);

    // Terminal flags.
    always_comb begin
        seq_done = (state == ST_FINISHED);
        seq_err  = (state == ST_FAILED);
    end

    // Main step sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_WAIT_PWR;
            gap_cnt    <= '0;
            ref_cnt    <= '0;
            saved_refi <= '0;
        end else begin
            case (state)
                ST_WAIT_PWR: if (pwr_up_done) state <= ST_DESEL;
                ST_DESEL: begin
                    if (issue_ack) begin
                        gap_cnt <= '0;
                        state   <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (gap_cnt == GAP_W'(DESEL_GAP - 1)) state <= ST_PRECH;
                    else gap_cnt <= gap_cnt + 1'b1;
                end
                ST_PRECH: if (issue_ack) state <= ST_MRS2;
                ST_MRS2:  if (issue_ack) state <= ST_MRS3;
                ST_MRS3:  if (issue_ack) state <= ST_MRS1;
                ST_MRS1:  if (issue_ack) state <= ST_MRS0;
                ST_MRS0:  if (issue_ack) state <= ST_ZQ;
                ST_ZQ:    if (issue_ack) state <= ST_SAVE_REFI;
                ST_SAVE_REFI: begin
                    saved_refi <= refi_rd;
                    state      <= ST_TRAIN;
                end
                ST_TRAIN: begin
                    if (gate_pass) begin
                        ref_cnt <= '0;
                        state   <= ST_REF_BURST;
                    end else if (gate_tmo) begin
                        state <= ST_FAILED;
                    end
                end
                ST_REF_BURST: begin
                    if (issue_ack) begin
                        if (ref_cnt == REF_W'(REF_BURST - 1)) state <= ST_RESTORE_REFI;
                        else ref_cnt <= ref_cnt + 1'b1;
                    end
                end
                ST_RESTORE_REFI: state <= ST_FINISHED;
                ST_FINISHED:     state <= ST_FINISHED;
                ST_FAILED:       state <= ST_FAILED;
                default:         state <= ST_WAIT_PWR;
            endcase
        end
    end

    seq_cmd_issuer #(
        .ADDR_W (MR_W),
        .BANK_W (BANK_W)
    ) u_issuer (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (issue_go),
        .code_in  (issue_code),
        .bank_in  (issue_bank),
        .addr_in  (issue_addr),
        .cmd_busy (cmd_busy),
        .cmd_req  (cmd_req),
        .cmd_code (cmd_code),
        .cmd_bank (cmd_bank),
        .cmd_addr (cmd_addr),
        .ack      (issue_ack)
    );

    seq_gate_cal #(
        .LANES   (LANES),
        .TIMEOUT (CAL_TIMEOUT)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (gate_go),
        .cal_done  (cal_done),
        .cal_start (cal_start),
        .finished  (gate_pass),
        .timed_out (gate_tmo)
    );

    // R1: silent until power-up completes
    p_silent_before_pwr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_PWR) |-> (!cmd_req && !refi_wr_en && !cal_start));

    // R6: no refresh-interval write while calibration strobe is high
    p_no_write_in_cal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        refi_wr_en |-> !cal_start);

    // R8: completion is sticky
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> seq_done);

    // R9: error is sticky and silences the outputs
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> (seq_err && !seq_done && !cmd_req && !refi_wr_en && !cal_start));

endmodule

// File: tb/tb_ddr3_bringup_seq.sv
module tb_ddr3_bringup_seq;

    localparam int MRW  = 13;
    localparam int RW   = 16;
    localparam int GAP  = 3;
    localparam int TMO  = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pwr_up_done = 1'b0;
    logic [MRW-1:0]  mr0 = '0, mr1 = '0, mr2 = '0, mr3 = '0;
    logic            cmd_busy = 1'b0;
    logic            cmd_req;
    logic [3:0]      cmd_code;
    logic [1:0]      cmd_rank;
    logic [2:0]      cmd_bank;
    logic [MRW-1:0]  cmd_addr;
    logic [RW-1:0]   refi_rd = '0;
    logic            refi_wr_en;
    logic [RW-1:0]   refi_wr_data;
    logic            cal_start;
    logic [1:0]      cal_done = '0;
    logic            seq_done;
    logic            seq_err;

    always #5 clk = ~clk;

    ddr3_bringup_seq #(
        .DESEL_GAP   (GAP),
        .CAL_TIMEOUT (TMO)
    ) dut (
        .clk (clk), .rst_n (rst_n), .pwr_up_done (pwr_up_done),
        .mode_reg0 (mr0), .mode_reg1 (mr1), .mode_reg2 (mr2), .mode_reg3 (mr3),
        .cmd_busy (cmd_busy), .cmd_req (cmd_req), .cmd_code (cmd_code),
        .cmd_rank (cmd_rank), .cmd_bank (cmd_bank), .cmd_addr (cmd_addr),
        .refi_rd (refi_rd), .refi_wr_en (refi_wr_en), .refi_wr_data (refi_wr_data),
        .cal_start (cal_start), .cal_done (cal_done),
        .seq_done (seq_done), .seq_err (seq_err)
    );

    int errs = 0;
    int checks = 0;
    bit reported = 0;

    int rc_code [16];
    int rc_rank [16];
    int rc_bank [16];
    int rc_addr [16];
    int rc_time [16];
    int n_cmd;
    int wr_val [4];
    int wr_pos [4];
    int n_wr;
    int cal_hi, cal_pos;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
        end
    endtask

    task automatic run(input int blen, input int lo, input int hi, input int seed);
        int bcnt;
        int post;
        int slow;
        bit ok_run;
        int exp_code [10];
        int exp_bank [10];
        int exp_addr [10];
        int exp_n;
        int m;
        mr0 = MRW'((seed * 37 + 11) & 13'h1fff);
        mr1 = MRW'((seed * 53 + 341) & 13'h1fff);
        mr2 = MRW'((seed * 71 + 682) & 13'h1fff);
        mr3 = MRW'((seed * 97 + 1023) & 13'h1fff);
        if (seed % 2 == 1) mr0 = mr0 | 13'h100; else mr0 = mr0 & ~13'h100;
        refi_rd = RW'(16'h0300 + seed);
        rst_n = 1'b0; pwr_up_done = 1'b0; cmd_busy = 1'b0; cal_done = '0;
        n_cmd = 0; n_wr = 0; cal_hi = 0; cal_pos = -1; bcnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!cmd_req && !refi_wr_en && !cal_start && !seq_done && !seq_err, "R1 reset",
            int'({cmd_req, refi_wr_en, cal_start, seq_done, seq_err}), 0);
        slow = 0;
        repeat (6) begin
            @(negedge clk);
            if (cmd_req || refi_wr_en) slow++;
        end
        chk(slow == 0, "R1 quiet before power-up", slow, 0);
        pwr_up_done = 1'b1;
        post = 0;
        for (int t = 0; t < 600; t++) begin
            @(negedge clk);
            if (cmd_req) begin
                if (n_cmd < 16) begin
                    rc_code[n_cmd] = cmd_code;
                    rc_rank[n_cmd] = cmd_rank;
                    rc_bank[n_cmd] = cmd_bank;
                    rc_addr[n_cmd] = cmd_addr;
                    rc_time[n_cmd] = t;
                end
                n_cmd++;
                if (blen > 0) begin cmd_busy = 1'b1; bcnt = blen; end
            end else if (cmd_busy) begin
                bcnt--;
                if (bcnt == 0) cmd_busy = 1'b0;
            end
            if (refi_wr_en) begin
                if (n_wr < 4) begin
                    wr_val[n_wr] = refi_wr_data;
                    wr_pos[n_wr] = n_cmd;
                end
                n_wr++;
            end
            if (cal_start) begin
                if (cal_hi == 0) begin
                    cal_pos = n_cmd;
                    refi_rd = RW'(16'h7a00 + seed);
                end
                cal_hi++;
                cal_done = {cal_hi >= hi, cal_hi >= lo};
            end else begin
                cal_done = '0;
            end
            if (seq_done || seq_err) post++;
            if (post > 15) break;
        end

        ok_run = (lo > hi ? lo : hi) <= TMO;
        exp_code = '{0, 1, 3, 3, 3, 3, 5, 2, 2, 2};
        exp_bank = '{0, 0, 2, 3, 1, 0, 0, 0, 0, 0};
        exp_addr = '{0, 0, int'(mr2), int'(mr3), int'(mr1), int'(mr0 | 13'h100), 0, 0, 0, 0};
        exp_n = ok_run ? 10 : 7;
        m = (blen > 1) ? blen : 1;

        chk(n_cmd == exp_n, ok_run ? "R8 command count" : "R9 command count", n_cmd, exp_n);
        for (int i = 0; i < exp_n && i < n_cmd; i++) begin
            chk(rc_code[i] == exp_code[i], "R3 code", rc_code[i], exp_code[i]);
            chk(rc_bank[i] == exp_bank[i], "R3 bank", rc_bank[i], exp_bank[i]);
            chk(rc_addr[i] == exp_addr[i], "R4 address", rc_addr[i], exp_addr[i]);
            chk(rc_rank[i] == 3, "R2 rank mask", rc_rank[i], 3);
        end
        for (int i = 1; i < exp_n && i < n_cmd; i++) begin
            if (i <= 6 || i >= 8) begin
                int e;
                e = m + 2 + ((i == 1) ? GAP : 0);
                chk(rc_time[i] - rc_time[i-1] == e, (i == 1) ? "R5 deselect gap" : "R10 spacing",
                    rc_time[i] - rc_time[i-1], e);
            end
        end
        chk(n_wr == (ok_run ? 2 : 1), "R6 write count", n_wr, ok_run ? 2 : 1);
        if (n_wr >= 1) begin
            chk(wr_val[0] == 0, "R6 zero write", wr_val[0], 0);
            chk(wr_pos[0] == 7, "R6 zero write after ZQ", wr_pos[0], 7);
        end
        chk(cal_pos == 7, "R7 start after zero write", cal_pos, 7);
        if (ok_run) begin
            chk(cal_hi == (lo > hi ? lo : hi), "R7 strobe length", cal_hi, lo > hi ? lo : hi);
            if (n_wr >= 2) begin
                chk(wr_val[1] == 16'h0300 + seed, "R8 restored interval", wr_val[1], 16'h0300 + seed);
                chk(wr_pos[1] == 10, "R8 restore after refreshes", wr_pos[1], 10);
            end
            chk(seq_done && !seq_err, "R8 done flag", int'({seq_done, seq_err}), 2);
        end else begin
            chk(cal_hi == TMO, "R9 strobe length", cal_hi, TMO);
            chk(seq_err && !seq_done, "R9 error flag", int'({seq_done, seq_err}), 1);
        end
    endtask

    initial begin
        int lo_t [6];
        int hi_t [6];
        int seed;
        lo_t = '{1, 2, 5, TMO, TMO + 1, 1};
        hi_t = '{1, 5, 2, TMO, 1, TMO + 3};
        seed = 0;
        for (int b = 0; b < 4; b++) begin
            for (int k = 0; k < 6; k++) begin
                run(b, lo_t[k], hi_t[k], seed);
                seed++;
            end
        end
        summary();
        $finish;
    end

    initial begin
        #2_000_000ns;
        errs++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

endmodule